// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds a small set of recently used virtual-to-physical page mappings and translates a lookup in the same cycle it is presented. Every slot is compared at once against the incoming virtual page number. A slot matches only when it is valid, its page number is equal, and either its address space tag equals the current one or the slot is marked global. On a match the block returns the frame number, the full physical address (the page offset passes straight through, since virtual and physical pages are the same size) and a permission fault flag built from the slot's write and user rights.

A miss is only reported. Fetching the mapping from memory is left to surrounding logic, which then writes it in through the load port. A load rewrites the slot that already holds the same page for the same address space, if there is one. Otherwise it takes the lowest-numbered empty slot. Once the table is full, it takes a slot picked by a free-running pseudo-random sequence. A flush control empties the whole table in one cycle.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits only when some valid slot has an equal page number and, for a non-global slot, an equal address space tag. On a miss, the frame output is zero.
- R2: A slot loaded with the global attribute hits for its page number under any address space tag.
- R3: The physical address output is the frame number in the upper bits and the lookup offset unchanged in the low bits. On a miss the upper bits are zero.
- R4: The fault output is high only on a hit where either a write is requested and the slot's writable bit is 0, or a user access is requested and the slot's user bit is 0. Writable=1 permits writes, and user=1 permits user access.
- R5: While any slot is empty, a load of a new mapping goes to the lowest empty slot, so up to ENTRIES distinct loads are all retained.
- R6: When every slot is full, a new mapping evicts exactly one slot. The choice comes from a free-running LFSR whose state is never zero, so slot 0 is never the victim.
- R7: Loading a page already present for the same address space (or with a global attribute on either side) overwrites that slot, so a lookup never matches two slots.
- R8: A flush empties every slot on the next edge. A load in the same cycle as a flush is dropped.
- R9: After reset, the table is empty and every lookup misses.
- R10: Lookup results are combinational from the lookup inputs. A load takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W (20) | Lookup virtual page number |
| lk_asid | input | ASID_W (6) | Current address space tag |
| lk_offset | input | OFF_W (12) | Page offset of the lookup address |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup is a user-mode access |
| lk_hit | output | 1 | A slot matched |
| lk_pfn | output | PFN_W (20) | Matched frame number, zero on miss |
| lk_pa | output | PFN_W+OFF_W | Translated physical address |
| lk_fault | output | 1 | Hit whose rights deny the access |
| ld_en | input | 1 | Load a mapping this cycle |
| ld_vpn | input | VPN_W | Page number to load |
| ld_asid | input | ASID_W | Address space tag to load |
| ld_pfn | input | PFN_W | Frame number to load |
| ld_global | input | 1 | Mapping ignores the address space tag |
| ld_writable | input | 1 | Mapping permits writes |
| ld_user | input | 1 | Mapping permits user access |
| flush_all | input | 1 | Invalidate all slots |

## Verification
The checker verifies the following on every cycle:
- a fault never appears without a hit;
- the frame output is zero on a miss;
- the offset always passes through unchanged;
- at most one slot matches a lookup;
- a flush leaves no valid slot;
- the LFSR state never reaches zero.

Only the bench's scenarios can show the following, because each depends on a sequence of loads and lookups:
- which mappings survive a fill of the full table;
- that a reload replaces a mapping instead of adding one;
- that a global mapping answers under a foreign tag;
- that a load issued together with a flush is lost.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic glob;
    logic wr_ok;
    logic usr_ok;
  } tlb_attr_t;

  function automatic int lfsr_tap(int w);
    case (w)
      2: return 0;
      3: return 1;
      4: return 2;
      5: return 2;
      default: return w - 2;
    endcase
  endfunction
endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 6
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0]             glob,
  input  logic [N-1:0][VPN_W-1:0]  vpn_arr,
  input  logic [N-1:0][ASID_W-1:0] asid_arr,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  input  logic                     any_asid,
  output logic [N-1:0]             match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic vpn_eq, asid_ok;
    assign vpn_eq  = (vpn_arr[i] == key_vpn);
    assign asid_ok = glob[i] | any_asid | (asid_arr[i] == key_asid);
    assign match[i] = valid[i] & vpn_eq & asid_ok;
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid,
  output logic [IW-1:0] victim,
  output logic [IW-1:0] rnd_idx
);
  import tlb_pkg::*;
  localparam int TAP = lfsr_tap(IW);

  logic [IW-1:0] lfsr_q, lfsr_d;
  logic          lfsr_en;
  logic [IW-1:0] free_idx;
  logic          any_free;

  assign lfsr_en = 1'b1;

  always_comb begin
    lfsr_d = {lfsr_q[IW-2:0], lfsr_q[IW-1] ^ lfsr_q[TAP]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lfsr_q <= IW'(1);
    else if (lfsr_en) lfsr_q <= lfsr_d;
  end

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  assign rnd_idx = lfsr_q;
  assign victim  = any_free ? free_idx : lfsr_q;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 6,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [ASID_W-1:0]      lk_asid,
  input  logic [OFF_W-1:0]       lk_offset,
  input  logic                   lk_write,
  input  logic                   lk_user,
  output logic                   lk_hit,
  output logic [PFN_W-1:0]       lk_pfn,
  output logic [PFN_W+OFF_W-1:0] lk_pa,
  output logic                   lk_fault,
  input  logic                   ld_en,
  input  logic [VPN_W-1:0]       ld_vpn,
  input  logic [ASID_W-1:0]      ld_asid,
  input  logic [PFN_W-1:0]       ld_pfn,
  input  logic                   ld_global,
  input  logic                   ld_writable,
  input  logic                   ld_user,
  input  logic                   flush_all
);
  import tlb_pkg::*;
  localparam int IW = $clog2(ENTRIES);

  logic                             rst_sync_n;
  logic [ENTRIES-1:0]               valid_q, valid_d;
  logic [ENTRIES-1:0][VPN_W-1:0]    vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0]   asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]    pfn_q;
  tlb_attr_t [ENTRIES-1:0]          attr_q;
  logic [ENTRIES-1:0]               glob_vec;
  logic [ENTRIES-1:0]               hit_vec, dup_vec;
  logic [IW-1:0]                    victim, rnd_idx, fill_idx;
  logic                             wr_en;
  tlb_attr_t                        hit_attr;

  tlb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) glob_vec[i] = attr_q[i].glob;
  end

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .valid    (valid_q),
    .glob     (glob_vec),
    .vpn_arr  (vpn_q),
    .asid_arr (asid_q),
    .key_vpn  (lk_vpn),
    .key_asid (lk_asid),
    .any_asid (1'b0),
    .match    (hit_vec)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_ld_match (
    .valid    (valid_q),
    .glob     (glob_vec),
    .vpn_arr  (vpn_q),
    .asid_arr (asid_q),
    .key_vpn  (ld_vpn),
    .key_asid (ld_asid),
    .any_asid (ld_global),
    .match    (dup_vec)
  );

  tlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .valid   (valid_q),
    .victim  (victim),
    .rnd_idx (rnd_idx)
  );

  // lookup side: one-hot select of frame and attributes
  always_comb begin
    lk_pfn   = '0;
    hit_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        lk_pfn   = lk_pfn | pfn_q[i];
        hit_attr = hit_attr | attr_q[i];
      end
    end
  end

  assign lk_hit   = |hit_vec;
  assign lk_pa    = {lk_pfn, lk_offset};
  assign lk_fault = lk_hit & ((lk_write & ~hit_attr.wr_ok) | (lk_user & ~hit_attr.usr_ok));

  // fill side: existing duplicate first, else victim picker
  always_comb begin
    fill_idx = victim;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup_vec[i]) fill_idx = IW'(i);
    end
  end

  assign wr_en = ld_en & ~flush_all;

  always_comb begin
    valid_d = valid_q;
    if (flush_all) begin
      valid_d = '0;
    end else if (ld_en) begin
      valid_d = valid_q & ~dup_vec;
      valid_d[fill_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= '0;
    else             valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[fill_idx]  <= ld_vpn;
      asid_q[fill_idx] <= ld_asid;
      pfn_q[fill_idx]  <= ld_pfn;
      attr_q[fill_idx] <= '{glob: ld_global, wr_ok: ld_writable, usr_ok: ld_user};
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int N     = 8,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12,
  parameter int IW    = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_hit,
  input logic                   lk_fault,
  input logic [PFN_W-1:0]       lk_pfn,
  input logic [PFN_W+OFF_W-1:0] lk_pa,
  input logic [OFF_W-1:0]       lk_offset,
  input logic [N-1:0]           hit_vec,
  input logic [N-1:0]           valid_vec,
  input logic                   ld_en,
  input logic                   flush_all,
  input logic [IW-1:0]          rnd_idx
);
  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  assert_fault_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);
  assert_miss_zero_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pfn == '0));
  assert_offset_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_pa[OFF_W-1:0] == lk_offset);
  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));
  assert_load_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !flush_all && up_cnt == 2'd3) |=> (valid_vec != '0));
  assert_rnd_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd3) |-> (rnd_idx != '0));
endmodule

bind asid_tlb tlb_chk #(.N(ENTRIES), .PFN_W(PFN_W), .OFF_W(OFF_W), .IW($clog2(ENTRIES))) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_hit    (lk_hit),
  .lk_fault  (lk_fault),
  .lk_pfn    (lk_pfn),
  .lk_pa     (lk_pa),
  .lk_offset (lk_offset),
  .hit_vec   (hit_vec),
  .valid_vec (valid_q),
  .ld_en     (ld_en),
  .flush_all (flush_all),
  .rnd_idx   (rnd_idx)
);

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 20, PFN_W = 20, ASID_W = 6, OFF_W = 12, ENTRIES = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [VPN_W-1:0] lk_vpn;
  logic [ASID_W-1:0] lk_asid;
  logic [OFF_W-1:0] lk_offset;
  logic lk_write, lk_user, lk_hit, lk_fault;
  logic [PFN_W-1:0] lk_pfn;
  logic [PFN_W+OFF_W-1:0] lk_pa;
  logic ld_en, ld_global, ld_writable, ld_user, flush_all;
  logic [VPN_W-1:0] ld_vpn;
  logic [ASID_W-1:0] ld_asid;
  logic [PFN_W-1:0] ld_pfn;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb dut (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_offset(lk_offset),
    .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_pa(lk_pa),
    .lk_fault(lk_fault), .ld_en(ld_en), .ld_vpn(ld_vpn), .ld_asid(ld_asid), .ld_pfn(ld_pfn),
    .ld_global(ld_global), .ld_writable(ld_writable), .ld_user(ld_user), .flush_all(flush_all)
  );

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic look(int vpn, int asid, bit wr = 0, bit usr = 0, int off = 12'h0);
    @(negedge clk);
    lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid); lk_write = wr; lk_user = usr;
    lk_offset = OFF_W'(off);
    #1;
  endtask

  task automatic load(int vpn, int asid, int pfn, bit g = 0, bit w = 1, bit u = 1, bit fl = 0);
    @(negedge clk);
    ld_en = 1'b1; ld_vpn = VPN_W'(vpn); ld_asid = ASID_W'(asid); ld_pfn = PFN_W'(pfn);
    ld_global = g; ld_writable = w; ld_user = u; flush_all = fl;
    @(negedge clk);
    ld_en = 1'b0; flush_all = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
  endtask

  task automatic t_reset();
    look(5, 0);
    chk("R9 hit after reset", lk_hit, 0);
    chk("R1 frame on miss", lk_pfn, 0);
  endtask

  task automatic t_basic();
    flush();
    load(20'h12345, 3, 20'hABCDE);
    look(20'h12345, 3, 0, 0, 12'h7F1);
    chk("R10 hit after load", lk_hit, 1);
    chk("R1 frame", lk_pfn, 20'hABCDE);
    chk("R3 phys addr", lk_pa, {20'hABCDE, 12'h7F1});
    look(20'h12345, 4, 0, 0, 12'h055);
    chk("R1 other tag misses", lk_hit, 0);
    chk("R3 miss addr", lk_pa, {20'h0, 12'h055});
    look(20'h12346, 3);
    chk("R1 other page misses", lk_hit, 0);
  endtask

  task automatic t_global();
    flush();
    load(20'h00777, 1, 20'h00888, 1);
    look(20'h00777, 45);
    chk("R2 global any tag", lk_hit, 1);
    chk("R2 global frame", lk_pfn, 20'h00888);
  endtask

  task automatic t_perm();
    flush();
    load(20'h00010, 2, 20'h00100, 0, 0, 1);
    load(20'h00020, 2, 20'h00200, 0, 1, 0);
    look(20'h00010, 2, 1, 0); chk("R4 write denied", lk_fault, 1);
    look(20'h00010, 2, 0, 1); chk("R4 read user ok", lk_fault, 0);
    look(20'h00020, 2, 0, 1); chk("R4 user denied", lk_fault, 1);
    look(20'h00020, 2, 1, 0); chk("R4 write ok", lk_fault, 0);
    look(20'h00030, 2, 1, 1); chk("R4 no fault on miss", lk_fault, 0);
  endtask

  task automatic t_fill_reload();
    int hits;
    flush();
    for (int i = 0; i < ENTRIES; i++) load(100 + i, 1, 200 + i);
    hits = 0;
    for (int i = 0; i < ENTRIES; i++) begin look(100 + i, 1); hits += int'(lk_hit); end
    chk("R5 all fills kept", hits, ENTRIES);
    load(103, 1, 999);
    hits = 0;
    for (int i = 0; i < ENTRIES; i++) begin look(100 + i, 1); hits += int'(lk_hit); end
    chk("R7 reload keeps others", hits, ENTRIES);
    look(103, 1);
    chk("R7 reload new frame", lk_pfn, 999);
  endtask

  task automatic t_replace();
    int hits;
    flush();
    for (int i = 0; i < ENTRIES; i++) load(300 + i, 2, 400 + i);
    load(600, 2, 700);
    hits = 0;
    for (int i = 0; i < ENTRIES; i++) begin look(300 + i, 2); hits += int'(lk_hit); end
    chk("R6 exactly one evicted", hits, ENTRIES - 1);
    look(300, 2); chk("R6 slot 0 survives", lk_hit, 1);
    look(600, 2); chk("R6 new mapping present", lk_hit, 1);
    chk("R6 new frame", lk_pfn, 700);
  endtask

  task automatic t_flush();
    load(20'h0AAAA, 5, 20'h0BBBB);
    flush();
    look(20'h0AAAA, 5); chk("R8 flush empties", lk_hit, 0);
    look(600, 2); chk("R8 flush empties older", lk_hit, 0);
    load(20'h0CCCC, 5, 20'h0DDDD, 0, 1, 1, 1);
    look(20'h0CCCC, 5); chk("R8 load with flush dropped", lk_hit, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_en = 0; flush_all = 0; ld_vpn = '0; ld_asid = '0; ld_pfn = '0;
    ld_global = 0; ld_writable = 0; ld_user = 0;
    lk_vpn = '0; lk_asid = '0; lk_offset = '0; lk_write = 0; lk_user = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_global();
    t_perm();
    t_fill_reload();
    t_replace();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule